// File: doc/BRIEF.md
# Field Coherence Maintenance Supervisor

This block watches the slow health of one sub-array of a phased-array panel and decides when the beam-weight tables need attention. Each time a new set of filtered metrics arrives, it compares them with thresholds. The metrics are temperature step, temperature rate, phase error and amplitude error, together with a power/bias step flag and a flag saying that the correction values are close to saturation. From the result it escalates in stages. A mild drift triggers a light compensation refresh. A hard limit, or a drift with no correction headroom left, triggers a full re-calibration. A failed re-calibration puts the sub-array into a degraded mode, where weight updates are frozen and the last-known-good table stays active.

Leaving degraded mode takes three things in order: a passing re-calibration, a passing validation, and an unbroken dwell with quiet metrics. Any violating metric sample during the dwell restarts it. Each logged transition writes one fixed-width event record into a small RAM ring that overwrites its oldest entry. The record holds a free-running timestamp, the sub-array ID, a reason code, a severity and the active table version. The compensation and re-calibration engines are outside this block. They receive request lines from it and return done and pass/fail pulses.

Top module: `coherence_supervisor`

## Requirements
- R1: After reset the supervisor is in normal service (state code 0), the compensation request, the re-cal request, the freeze output and the trend warning are all low, the active version is 0, the log write pointer is 0 and the log-wrapped flag is low.
- R2: A metric sample in normal service with a hard-limit crossing moves to re-calibration (state 3) and raises the re-cal request. A hard-limit crossing is temperature step >= 60, phase error >= 100, or amplitude error >= 100. The move writes one record with code 3 (re-cal start) and severity 2 (alarm).
- R3: A metric sample in normal service with a drift trigger and no hard crossing moves to drift detected (state 1) and writes code 1 with severity 1 (warn). A drift trigger is any of: temperature step >= 20, temperature rate >= 16, power step flag, phase error >= 40, amplitude error >= 40, headroom-low flag. One cycle later the state becomes compensation (state 2, compensation request high), with no record. If headroom-low was set in that sample, the state becomes re-calibration instead, with a record of code 3 and severity 1.
- R4: A sample in normal service with phase or amplitude error >= 24, but with no drift trigger, keeps the state at 0, sets the trend warning and writes no record. A sample below every level clears the trend warning and writes no record.
- R5: In compensation, a done pulse returns the block to normal service, writes code 2 (compensation applied) with severity 0 (info), and makes the offered table version active. If a hard-limit sample arrives in that same cycle or earlier, it wins: the block moves to re-calibration and writes code 7 (rollback) with severity 2.
- R6: In re-calibration, a passing done pulse returns the block to normal service, writes code 4 (re-cal ok) with severity 0 and makes the offered version active. A failing done pulse enters degraded mode (state 4) and writes code 6 (degraded enter) with severity 2.
- R7: In degraded mode the freeze output is high and the active version does not change, whatever version is offered. The re-cal request stays high until a re-cal passes. Each failing re-cal in degraded mode writes code 5 (re-cal fail) with severity 2 and keeps the request high.
- R8: Once a re-cal has passed in degraded mode, a validation pulse is awaited. A failing validation raises the re-cal request again. A passing validation starts a dwell of DWELL cycles. Any metric sample with a drift or hard trigger during the dwell restarts it. When the dwell completes, the block returns to normal service, writes code 4 with severity 0 and makes the offered version active.
- R9: Each record is, from most to least significant bit: {timestamp, sub-array ID, code[2:0], severity[1:0], version}. The version field holds the active version after the transition. The write pointer advances by one per record, modulo DEPTH, overwriting the oldest entry. The wrapped flag sets once DEPTH records have been written. Timestamps strictly increase from older to newer records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| metric_valid | input | 1 | One-cycle strobe: a new metric sample is present |
| temp_step | input | MW | Magnitude of filtered temperature change |
| temp_rate | input | MW | Magnitude of temperature rate of change |
| phase_err | input | MW | Magnitude of residual phase error |
| amp_err | input | MW | Magnitude of residual amplitude error |
| power_step | input | 1 | Power or bias state step in this sample |
| headroom_low | input | 1 | Correction value close to saturation |
| comp_done | input | 1 | Compensation engine finished |
| recal_done | input | 1 | Re-calibration engine finished |
| recal_pass | input | 1 | Re-calibration outcome, valid with recal_done |
| val_done | input | 1 | Validation finished |
| val_pass | input | 1 | Validation outcome, valid with val_done |
| new_ver | input | VER_W | Version of the table offered by the engines |
| subarray_id | input | SA_W | Sub-array identifier placed in records |
| log_rd_idx | input | AW | Ring read address |
| state_o | output | 3 | Current state code |
| comp_req | output | 1 | Compensation refresh request |
| recal_req | output | 1 | Re-calibration request |
| freeze | output | 1 | Weight updates frozen |
| trend_warn | output | 1 | Trend near limits, still in normal service |
| lkg_ver | output | VER_W | Active (last-known-good) table version |
| log_rd_data | output | REC_W | Record at log_rd_idx |
| log_wr_ptr | output | AW | Next ring slot to be written |
| log_wrapped | output | 1 | Ring has filled at least once |

## Verification
The bench builds the block with DEPTH = 8 and DWELL = 20, with the default thresholds. With an eight-entry ring, the directed paths alone overwrite the oldest records, and the random phase wraps the ring several more times. With a 20-cycle dwell, a restart in the middle of a dwell and the later clean exit both fit within a few tens of cycles, with wide margins either side of the exit edge. The random samples span values below the warning level up to above the hard limits, so trend, drift, headroom-escalation and hard-limit paths are mixed in unpredictable order.

// File: rtl/coh_pkg.sv
// Shared encodings for the coherence supervisor.
// Assumes: state, event and severity codes are fixed because they appear in
// log records and on state_o, and software decodes them.
package coh_pkg;
    typedef enum logic [2:0] {
        ST_NORMAL   = 3'd0,
        ST_DRIFT    = 3'd1,
        ST_COMP     = 3'd2,
        ST_RECAL    = 3'd3,
        ST_DEGRADED = 3'd4
    } coh_state_e;

    typedef enum logic [1:0] {
        DG_RECAL = 2'd0,
        DG_VALID = 2'd1,
        DG_DWELL = 2'd2
    } dg_phase_e;

    typedef enum logic [2:0] {
        EV_NONE        = 3'd0,
        EV_DRIFT       = 3'd1,
        EV_COMP        = 3'd2,
        EV_RECAL_START = 3'd3,
        EV_RECAL_OK    = 3'd4,
        EV_RECAL_FAIL  = 3'd5,
        EV_DEGRADED    = 3'd6,
        EV_ROLLBACK    = 3'd7
    } ev_code_e;

    typedef enum logic [1:0] {
        SEV_INFO  = 2'd0,
        SEV_WARN  = 2'd1,
        SEV_ALARM = 2'd2
    } sev_e;
endpackage

// File: rtl/coh_trigger_eval.sv
// Threshold comparator for one metric sample.
// Produces three nested classes: hard (limit breached), drift (any soft
// trigger or hard), trend (error near its limit). Purely combinational.
// Assumes: metrics are unsigned magnitudes and each hard level lies above
// the matching soft level.
module coh_trigger_eval #(
    parameter int MW        = 8,
    parameter int TS_SOFT   = 20,
    parameter int TS_HARD   = 60,
    parameter int RT_SOFT   = 16,
    parameter int PH_WARN   = 24,
    parameter int PH_SOFT   = 40,
    parameter int PH_HARD   = 100,
    parameter int AM_WARN   = 24,
    parameter int AM_SOFT   = 40,
    parameter int AM_HARD   = 100
) (
    input  logic [MW-1:0] temp_step,
    input  logic [MW-1:0] temp_rate,
    input  logic [MW-1:0] phase_err,
    input  logic [MW-1:0] amp_err,
    input  logic          power_step,
    input  logic          headroom_low,
    output logic          hard,
    output logic          drift,
    output logic          trend
);
    // Classify the sample against all thresholds.
    always_comb begin
        hard  = (temp_step >= MW'(TS_HARD)) || (phase_err >= MW'(PH_HARD)) ||
                (amp_err >= MW'(AM_HARD));
        drift = hard || (temp_step >= MW'(TS_SOFT)) || (temp_rate >= MW'(RT_SOFT)) ||
                power_step || headroom_low ||
                (phase_err >= MW'(PH_SOFT)) || (amp_err >= MW'(AM_SOFT));
        trend = (phase_err >= MW'(PH_WARN)) || (amp_err >= MW'(AM_WARN));
    end
endmodule

// File: rtl/coh_dwell_timer.sv
// Stable-dwell counter for the degraded-mode exit.
// Counts cycles while run is high; a kick or a low run clears it. done is
// high in the last cycle of an unbroken DWELL-cycle window.
// Assumes: DWELL >= 1.
module coh_dwell_timer #(
    parameter int DWELL = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic kick,
    output logic done
);
    localparam int CW = $clog2(DWELL + 1);

    logic [CW-1:0] cnt_q;

    // Completion when the window is full and the current cycle is quiet.
    assign done = run && !kick && (cnt_q == CW'(DWELL - 1));

    // Advance, restart or clear the dwell count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || kick || done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8: the count never passes the end of the window.
    assert_dwell_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DWELL - 1));

    // R8: a kick always restarts the window.
    assert_dwell_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt_q == '0));
endmodule

// File: rtl/coh_event_ring.sv
// Event record ring buffer.
// Writes one record per we pulse at wr_ptr and wraps, overwriting the oldest
// entry. Read is asynchronous by index. wrapped latches after the first fill.
// Assumes: DEPTH is a power of two.
module coh_event_ring #(
    parameter int REC_W = 33,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REC_W-1:0] wdata,
    input  logic [AW-1:0]    rd_idx,
    output logic [REC_W-1:0] rd_data,
    output logic [AW-1:0]    wr_ptr,
    output logic             wrapped
);
    logic [REC_W-1:0] mem_q [DEPTH];

    assign rd_data = mem_q[rd_idx];

    // Store records at the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[wr_ptr] <= wdata;
        end
    end

    // Move the pointer and note the first wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            wrapped <= 1'b0;
        end else if (we) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (wr_ptr == AW'(DEPTH - 1)) wrapped <= 1'b1;
        end
    end

    // R9: one slot per record.
    assert_ptr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (wr_ptr == $past(wr_ptr) + 1'b1));

    // R9: no movement without a record.
    assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(wr_ptr));
endmodule

// File: rtl/coherence_supervisor.sv
// Field coherence maintenance supervisor (top).
// Escalates drift handling: normal -> drift -> compensation, or straight to
// re-calibration, then to degraded mode on a failed re-cal. Degraded mode
// freezes the active version and leaves only after re-cal pass, validation
// pass and a quiet dwell. Logs each state change into the event ring.
// Assumes: done/pass inputs are one-cycle pulses from external engines;
// metrics are pre-filtered and only meaningful with metric_valid.
module coherence_supervisor
    import coh_pkg::*;
#(
    parameter int MW      = 8,
    parameter int VER_W   = 8,
    parameter int SA_W    = 4,
    parameter int TS_W    = 16,
    parameter int DEPTH   = 8,
    parameter int DWELL   = 20,
    parameter int TS_SOFT = 20,
    parameter int TS_HARD = 60,
    parameter int RT_SOFT = 16,
    parameter int PH_WARN = 24,
    parameter int PH_SOFT = 40,
    parameter int PH_HARD = 100,
    parameter int AM_WARN = 24,
    parameter int AM_SOFT = 40,
    parameter int AM_HARD = 100,
    localparam int AW     = $clog2(DEPTH),
    localparam int REC_W  = TS_W + SA_W + 3 + 2 + VER_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             metric_valid,
    input  logic [MW-1:0]    temp_step,
    input  logic [MW-1:0]    temp_rate,
    input  logic [MW-1:0]    phase_err,
    input  logic [MW-1:0]    amp_err,
    input  logic             power_step,
    input  logic             headroom_low,
    input  logic             comp_done,
    input  logic             recal_done,
    input  logic             recal_pass,
    input  logic             val_done,
    input  logic             val_pass,
    input  logic [VER_W-1:0] new_ver,
    input  logic [SA_W-1:0]  subarray_id,
    input  logic [AW-1:0]    log_rd_idx,
    output logic [2:0]       state_o,
    output logic             comp_req,
    output logic             recal_req,
    output logic             freeze,
    output logic             trend_warn,
    output logic [VER_W-1:0] lkg_ver,
    output logic [REC_W-1:0] log_rd_data,
    output logic [AW-1:0]    log_wr_ptr,
    output logic             log_wrapped
);
    coh_state_e       st_q, st_d;
    dg_phase_e        ph_q, ph_d;
    logic             sat_q, sat_d;
    logic             hard, drift, trend;
    logic             dwell_run, dwell_kick, dwell_done;
    logic             log_we, accept;
    ev_code_e         ev_code;
    sev_e             ev_sev;
    logic [TS_W-1:0]  ts_q;
    logic [VER_W-1:0] rec_ver;

    coh_trigger_eval #(
        .MW(MW), .TS_SOFT(TS_SOFT), .TS_HARD(TS_HARD), .RT_SOFT(RT_SOFT),
        .PH_WARN(PH_WARN), .PH_SOFT(PH_SOFT), .PH_HARD(PH_HARD),
        .AM_WARN(AM_WARN), .AM_SOFT(AM_SOFT), .AM_HARD(AM_HARD)
    ) u_eval (
        .temp_step(temp_step), .temp_rate(temp_rate), .phase_err(phase_err),
        .amp_err(amp_err), .power_step(power_step), .headroom_low(headroom_low),
        .hard(hard), .drift(drift), .trend(trend)
    );

    assign dwell_run  = (st_q == ST_DEGRADED) && (ph_q == DG_DWELL);
    assign dwell_kick = metric_valid && drift;

    coh_dwell_timer #(.DWELL(DWELL)) u_dwell (
        .clk(clk), .rst_n(rst_n), .run(dwell_run), .kick(dwell_kick), .done(dwell_done)
    );

    // Next-state, record request and version acceptance.
    always_comb begin
        st_d    = st_q;
        ph_d    = ph_q;
        sat_d   = sat_q;
        log_we  = 1'b0;
        accept  = 1'b0;
        ev_code = EV_NONE;
        ev_sev  = SEV_INFO;
        case (st_q)
            ST_NORMAL: begin
                if (metric_valid && hard) begin
                    st_d = ST_RECAL; log_we = 1'b1; ev_code = EV_RECAL_START; ev_sev = SEV_ALARM;
                end else if (metric_valid && drift) begin
                    st_d = ST_DRIFT; sat_d = headroom_low;
                    log_we = 1'b1; ev_code = EV_DRIFT; ev_sev = SEV_WARN;
                end
            end
            ST_DRIFT: begin
                if (sat_q) begin
                    st_d = ST_RECAL; log_we = 1'b1; ev_code = EV_RECAL_START; ev_sev = SEV_WARN;
                end else begin
                    st_d = ST_COMP;
                end
            end
            ST_COMP: begin
                if (metric_valid && hard) begin
                    st_d = ST_RECAL; log_we = 1'b1; ev_code = EV_ROLLBACK; ev_sev = SEV_ALARM;
                end else if (comp_done) begin
                    st_d = ST_NORMAL; accept = 1'b1;
                    log_we = 1'b1; ev_code = EV_COMP; ev_sev = SEV_INFO;
                end
            end
            ST_RECAL: begin
                if (recal_done && recal_pass) begin
                    st_d = ST_NORMAL; accept = 1'b1;
                    log_we = 1'b1; ev_code = EV_RECAL_OK; ev_sev = SEV_INFO;
                end else if (recal_done) begin
                    st_d = ST_DEGRADED; ph_d = DG_RECAL;
                    log_we = 1'b1; ev_code = EV_DEGRADED; ev_sev = SEV_ALARM;
                end
            end
            ST_DEGRADED: begin
                case (ph_q)
                    DG_RECAL: begin
                        if (recal_done && recal_pass) begin
                            ph_d = DG_VALID;
                        end else if (recal_done) begin
                            log_we = 1'b1; ev_code = EV_RECAL_FAIL; ev_sev = SEV_ALARM;
                        end
                    end
                    DG_VALID: begin
                        if (val_done) ph_d = val_pass ? DG_DWELL : DG_RECAL;
                    end
                    default: begin
                        if (dwell_done) begin
                            st_d = ST_NORMAL; ph_d = DG_RECAL; accept = 1'b1;
                            log_we = 1'b1; ev_code = EV_RECAL_OK; ev_sev = SEV_INFO;
                        end
                    end
                endcase
            end
            default: st_d = ST_NORMAL;
        endcase
    end

    // State, phase and headroom latch registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_NORMAL;
            ph_q  <= DG_RECAL;
            sat_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            ph_q  <= ph_d;
            sat_q <= sat_d;
        end
    end

    // Active version: taken only on an accepting transition.
    always_ff @(posedge clk) begin
        if (!rst_n)      lkg_ver <= '0;
        else if (accept) lkg_ver <= new_ver;
    end

    // Trend warning: refreshed by samples in normal service, cleared elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n)                             trend_warn <= 1'b0;
        else if (st_q != ST_NORMAL)             trend_warn <= 1'b0;
        else if (metric_valid)                  trend_warn <= trend && !drift;
    end

    // Free-running timestamp for records.
    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_q + 1'b1;
    end

    assign rec_ver   = accept ? new_ver : lkg_ver;
    assign state_o   = st_q;
    assign comp_req  = (st_q == ST_COMP);
    assign recal_req = (st_q == ST_RECAL) || ((st_q == ST_DEGRADED) && (ph_q == DG_RECAL));
    assign freeze    = (st_q == ST_DEGRADED);

    coh_event_ring #(.REC_W(REC_W), .DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n), .we(log_we),
        .wdata({ts_q, subarray_id, ev_code, ev_sev, rec_ver}),
        .rd_idx(log_rd_idx), .rd_data(log_rd_data),
        .wr_ptr(log_wr_ptr), .wrapped(log_wrapped)
    );

    // R2: a hard crossing in normal service goes straight to re-cal.
    assert_hard_recal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_NORMAL && metric_valid && hard) |=> (st_q == ST_RECAL && recal_req));

    // R3: drift detected lasts exactly one cycle.
    assert_drift_brief_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DRIFT) |=> (st_q == ST_COMP || st_q == ST_RECAL));

    // R6: a failing re-cal leads to frozen degraded mode.
    assert_fail_degrade_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RECAL && recal_done && !recal_pass) |=> (st_q == ST_DEGRADED && freeze));

    // R7: the active version holds while frozen.
    assert_freeze_ver_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && $past(freeze)) |-> $stable(lkg_ver));
endmodule

// File: tb/coherence_supervisor_bench.sv
module coherence_supervisor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MW = 8, VER_W = 8, SA_W = 4, TS_W = 16, DEPTH = 8, DWELL = 20;
    localparam int AW = $clog2(DEPTH);
    localparam int REC_W = TS_W + SA_W + 5 + VER_W;
    localparam int TS_SOFT = 20, TS_HARD = 60, RT_SOFT = 16;
    localparam int PH_WARN = 24, PH_SOFT = 40, PH_HARD = 100;
    localparam int AM_WARN = 24, AM_SOFT = 40, AM_HARD = 100;
    localparam logic [SA_W-1:0] SA = 4'hA;

    logic clk = 1'b0, rst_n = 1'b0;
    logic metric_valid = 0, power_step = 0, headroom_low = 0;
    logic [MW-1:0] temp_step = 0, temp_rate = 0, phase_err = 0, amp_err = 0;
    logic comp_done = 0, recal_done = 0, recal_pass = 0, val_done = 0, val_pass = 0;
    logic [VER_W-1:0] new_ver = 0;
    logic [AW-1:0] log_rd_idx = 0;
    logic [2:0] state_o;
    logic comp_req, recal_req, freeze, trend_warn, log_wrapped;
    logic [VER_W-1:0] lkg_ver;
    logic [REC_W-1:0] log_rd_data;
    logic [AW-1:0] log_wr_ptr;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [2:0] m_code [DEPTH];
    logic [1:0] m_sev [DEPTH];
    logic [VER_W-1:0] m_ver [DEPTH];
    int wr_total = 0;
    logic [VER_W-1:0] exp_lkg = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coherence_supervisor #(
        .MW(MW), .VER_W(VER_W), .SA_W(SA_W), .TS_W(TS_W), .DEPTH(DEPTH), .DWELL(DWELL),
        .TS_SOFT(TS_SOFT), .TS_HARD(TS_HARD), .RT_SOFT(RT_SOFT),
        .PH_WARN(PH_WARN), .PH_SOFT(PH_SOFT), .PH_HARD(PH_HARD),
        .AM_WARN(AM_WARN), .AM_SOFT(AM_SOFT), .AM_HARD(AM_HARD)
    ) u_coherence_supervisor (
        .clk(clk), .rst_n(rst_n), .metric_valid(metric_valid),
        .temp_step(temp_step), .temp_rate(temp_rate), .phase_err(phase_err), .amp_err(amp_err),
        .power_step(power_step), .headroom_low(headroom_low),
        .comp_done(comp_done), .recal_done(recal_done), .recal_pass(recal_pass),
        .val_done(val_done), .val_pass(val_pass), .new_ver(new_ver), .subarray_id(SA),
        .log_rd_idx(log_rd_idx), .state_o(state_o), .comp_req(comp_req), .recal_req(recal_req),
        .freeze(freeze), .trend_warn(trend_warn), .lkg_ver(lkg_ver), .log_rd_data(log_rd_data),
        .log_wr_ptr(log_wr_ptr), .log_wrapped(log_wrapped)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        chk(act == exp, req, act, exp);
    endtask

    // 0 quiet, 1 trend, 2 drift, 3 hard
    function automatic int classify(int ts, int tr, int ph, int am, bit ps, bit hl);
        if (ts >= TS_HARD || ph >= PH_HARD || am >= AM_HARD) return 3;
        if (ts >= TS_SOFT || tr >= RT_SOFT || ps || hl || ph >= PH_SOFT || am >= AM_SOFT) return 2;
        if (ph >= PH_WARN || am >= AM_WARN) return 1;
        return 0;
    endfunction

    task automatic expect_rec(input logic [2:0] code, input logic [1:0] sev, input logic [VER_W-1:0] ver);
        m_code[wr_total % DEPTH] = code;
        m_sev[wr_total % DEPTH]  = sev;
        m_ver[wr_total % DEPTH]  = ver;
        wr_total++;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int ts, input int tr, input int ph, input int am, input bit ps, input bit hl);
        @(negedge clk);
        temp_step = MW'(ts); temp_rate = MW'(tr); phase_err = MW'(ph); amp_err = MW'(am);
        power_step = ps; headroom_low = hl; metric_valid = 1;
        @(negedge clk);
        metric_valid = 0; temp_step = 0; temp_rate = 0; phase_err = 0; amp_err = 0;
        power_step = 0; headroom_low = 0;
    endtask

    task automatic pulse_comp();
        @(negedge clk); comp_done = 1;
        @(negedge clk); comp_done = 0;
    endtask

    task automatic pulse_recal(input bit pass);
        @(negedge clk); recal_done = 1; recal_pass = pass;
        @(negedge clk); recal_done = 0; recal_pass = 0;
    endtask

    task automatic pulse_val(input bit pass);
        @(negedge clk); val_done = 1; val_pass = pass;
        @(negedge clk); val_done = 0; val_pass = 0;
    endtask

    task automatic verify_log();
        int n;
        logic [TS_W-1:0] prev_ts;
        logic [REC_W-1:0] rec;
        chk_eq("R9 write pointer", log_wr_ptr, 64'(wr_total % DEPTH));
        chk_eq("R9 wrapped flag", log_wrapped, 64'(wr_total >= DEPTH));
        n = (wr_total < DEPTH) ? wr_total : DEPTH;
        prev_ts = '0;
        for (int i = 0; i < n; i++) begin
            int idx;
            idx = (wr_total - n + i) % DEPTH;
            log_rd_idx = AW'(idx);
            #1;
            rec = log_rd_data;
            chk_eq("R9 record code", rec[VER_W+4:VER_W+2], m_code[idx]);
            chk_eq("R9 record severity", rec[VER_W+1:VER_W], m_sev[idx]);
            chk_eq("R9 record version", rec[VER_W-1:0], m_ver[idx]);
            chk_eq("R9 record subarray", rec[VER_W+5+SA_W-1:VER_W+5], SA);
            if (i > 0) chk(rec[REC_W-1:REC_W-TS_W] > prev_ts, "R9 timestamp order",
                           rec[REC_W-1:REC_W-TS_W], prev_ts);
            prev_ts = rec[REC_W-1:REC_W-TS_W];
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'h5EED);
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 reset state
        chk_eq("R1 state", state_o, 0);
        chk_eq("R1 requests", {comp_req, recal_req, freeze, trend_warn}, 0);
        chk_eq("R1 version", lkg_ver, 0);
        chk_eq("R1 pointer", log_wr_ptr, 0);
        chk_eq("R1 wrapped", log_wrapped, 0);

        // R4 trend warning without leaving normal service
        send(0, 0, 30, 0, 0, 0);
        chk_eq("R4 state stays normal", state_o, 0);
        chk_eq("R4 trend warn set", trend_warn, 1);
        chk_eq("R4 no record", log_wr_ptr, 0);
        send(0, 0, 0, 0, 0, 0);
        chk_eq("R4 trend warn cleared", trend_warn, 0);

        // R3 drift via rate, then R5 compensation applied
        send(0, 20, 0, 0, 0, 0);
        chk_eq("R3 drift state", state_o, 1);
        expect_rec(3'd1, 2'd1, exp_lkg);
        tick(1);
        chk_eq("R3 compensation state", state_o, 2);
        chk_eq("R3 comp request", comp_req, 1);
        new_ver = 8'd5;
        pulse_comp();
        exp_lkg = 8'd5;
        expect_rec(3'd2, 2'd0, exp_lkg);
        chk_eq("R5 back to normal", state_o, 0);
        chk_eq("R5 version taken", lkg_ver, exp_lkg);
        verify_log();

        // R3 headroom-low escalates to re-cal, R6 pass
        send(0, 0, 0, 0, 0, 1);
        chk_eq("R3 drift state (headroom)", state_o, 1);
        expect_rec(3'd1, 2'd1, exp_lkg);
        tick(1);
        chk_eq("R3 headroom to recal", state_o, 3);
        chk_eq("R3 recal request", recal_req, 1);
        expect_rec(3'd3, 2'd1, exp_lkg);
        new_ver = 8'd6;
        pulse_recal(1);
        exp_lkg = 8'd6;
        expect_rec(3'd4, 2'd0, exp_lkg);
        chk_eq("R6 pass to normal", state_o, 0);
        chk_eq("R6 version taken", lkg_ver, exp_lkg);

        // R2 hard phase, R6 fail, R7 degraded, R8 exit
        send(0, 0, 120, 0, 0, 0);
        chk_eq("R2 hard to recal", state_o, 3);
        chk_eq("R2 recal request", recal_req, 1);
        expect_rec(3'd3, 2'd2, exp_lkg);
        pulse_recal(0);
        expect_rec(3'd6, 2'd2, exp_lkg);
        chk_eq("R6 fail to degraded", state_o, 4);
        chk_eq("R7 freeze", freeze, 1);
        chk_eq("R7 recal request held", recal_req, 1);
        new_ver = 8'd9;
        pulse_recal(0);
        expect_rec(3'd5, 2'd2, exp_lkg);
        chk_eq("R7 still degraded", state_o, 4);
        chk_eq("R7 request after fail", recal_req, 1);
        chk_eq("R7 version frozen", lkg_ver, exp_lkg);
        pulse_recal(1);
        chk_eq("R7 request drops after pass", recal_req, 0);
        pulse_val(0);
        chk_eq("R8 validation fail re-requests", recal_req, 1);
        pulse_recal(1);
        pulse_val(1);
        tick(12);
        chk_eq("R8 dwell not complete", state_o, 4);
        send(25, 0, 0, 0, 0, 0);
        tick(10);
        chk_eq("R8 dwell restarted", state_o, 4);
        chk_eq("R7 version frozen in dwell", lkg_ver, 8'd6);
        tick(12);
        exp_lkg = 8'd9;
        expect_rec(3'd4, 2'd0, exp_lkg);
        chk_eq("R8 exit to normal", state_o, 0);
        chk_eq("R8 freeze released", freeze, 0);
        chk_eq("R8 version taken on exit", lkg_ver, exp_lkg);

        // R5 rollback when a hard sample hits during compensation
        send(0, 0, 0, 0, 1, 0);
        expect_rec(3'd1, 2'd1, exp_lkg);
        tick(1);
        chk_eq("R5 in compensation", state_o, 2);
        send(0, 0, 0, 100, 0, 0);
        chk_eq("R5 rollback to recal", state_o, 3);
        expect_rec(3'd7, 2'd2, exp_lkg);
        pulse_recal(1);
        expect_rec(3'd4, 2'd0, exp_lkg);
        verify_log();

        // Random phase
        for (int it = 0; it < 40; it++) begin
            int ts, tr, ph, am, cls;
            bit ps, hl;
            ts = $urandom_range(0, 70); tr = $urandom_range(0, 18);
            ph = $urandom_range(0, 110); am = $urandom_range(0, 60);
            ps = ($urandom % 8) == 0; hl = ($urandom % 8) == 0;
            cls = classify(ts, tr, ph, am, ps, hl);
            send(ts, tr, ph, am, ps, hl);
            if (cls == 3) begin
                chk_eq("R2 random hard", state_o, 3);
                expect_rec(3'd3, 2'd2, exp_lkg);
                new_ver = VER_W'($urandom);
                pulse_recal(1);
                exp_lkg = new_ver;
                expect_rec(3'd4, 2'd0, exp_lkg);
            end else if (cls == 2) begin
                chk_eq("R3 random drift", state_o, 1);
                expect_rec(3'd1, 2'd1, exp_lkg);
                tick(1);
                new_ver = VER_W'($urandom);
                if (hl) begin
                    chk_eq("R3 random headroom recal", state_o, 3);
                    expect_rec(3'd3, 2'd1, exp_lkg);
                    pulse_recal(1);
                    exp_lkg = new_ver;
                    expect_rec(3'd4, 2'd0, exp_lkg);
                end else begin
                    chk_eq("R3 random compensation", state_o, 2);
                    pulse_comp();
                    exp_lkg = new_ver;
                    expect_rec(3'd2, 2'd0, exp_lkg);
                end
                chk_eq("R5 random version", lkg_ver, exp_lkg);
            end else begin
                chk_eq("R4 random stays normal", state_o, 0);
                chk_eq("R4 random trend", trend_warn, 64'(cls == 1));
            end
        end
        verify_log();
        finish_run();
    end
endmodule